// File: doc/BRIEF.md
# Frame-Type Priority Override Table

This block keeps one override record for each of 16 ingress frame types. Each record has three enable/value pairs: a queue-priority override for ordinary ports, a second queue-priority override for audio/video-bridging (AVB) ports, and a frame-priority override. On the datapath side, a classifier presents a frame-type index, the port's AVB flag and the priorities the frame already carries. In the same cycle the block returns the priorities to use and a flag for each one that says an override was applied.

Software reaches the table only through one 16-bit command word, `cfg_wdata`, and reads that word back on `cfg_rdata`. A write with bit 15 clear is a fetch. It copies the stored fields of the addressed record into the word, so the next read returns them. A write with bit 15 set is an update. The block holds bit 15 at 1 for one cycle while it writes the record, then clears the bit. To change one queue pair without disturbing the other, software fetches the record, edits the word, and writes it back with bit 15 set.

The control path is a two-state machine. `ST_IDLE` accepts fetches and updates. The transition `IDLE->COMMIT` is taken on a write with bit 15 set. `ST_COMMIT` writes the record and always takes `COMMIT->IDLE` on the next clock. Writes that arrive in `ST_COMMIT` are dropped.

Top module: `prio_override_table`

## Requirements
- R1: After reset every record has all enables and priority values at zero, `cfg_rdata` reads 0x0000, and every lookup passes the input priorities through with both override flags at 0.
- R2: An update with bit 12 = 0 writes a queue record at the index in bits [11:8]. It stores bit 3 as the normal queue enable, bits [1:0] as the normal queue priority, bit 7 as the AVB queue enable and bits [5:4] as the AVB queue priority. The frame fields of that record do not change.
- R3: An update with bit 12 = 1 writes the frame record at the index in bits [11:8]. It stores bit 3 as the frame enable and bits [2:0] as the frame priority. The queue fields of that record do not change.
- R4: After an update write, bit 15 of `cfg_rdata` reads 1 for exactly one cycle. After that, `cfg_rdata` equals the written word with bit 15 cleared, and the new record is visible to lookups.
- R5: Any write that arrives while bit 15 reads 1 is ignored. It changes neither the word nor the table.
- R6: A fetch (bit 15 = 0) makes `cfg_rdata` read as follows on the next cycle. Bits [11:8] hold the index and bit 12 holds the table select. For a queue fetch, the low byte holds the stored normal and AVB fields at their update positions. For a frame fetch, bits [3] and [2:0] hold the stored frame fields. Every other bit reads 0. A fetch does not change the table.
- R7: On a port with `lk_avb` = 0, the queue priority is the stored normal value when the normal enable is set, and `in_qpri` otherwise. `out_qovr` equals that enable.
- R8: On a port with `lk_avb` = 1, the AVB enable and value are used in place of the normal ones, with the same pass-through rule.
- R9: The frame priority is the stored value when the frame enable is set, and `in_fpri` otherwise. `out_fovr` equals that enable.
- R10: A fetch, then an edit of one queue pair, then an update leaves the other pair of the same record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the command word |
| cfg_wdata | input | 16 | Command word to write |
| cfg_rdata | output | 16 | Current command word |
| lk_type | input | 4 | Frame-type index of the frame being looked up |
| lk_avb | input | 1 | Ingress port is an AVB port |
| in_qpri | input | 2 | Queue priority before override |
| in_fpri | input | 3 | Frame priority before override |
| out_qpri | output | 2 | Queue priority after override |
| out_qovr | output | 1 | Queue override applied |
| out_fpri | output | 3 | Frame priority after override |
| out_fovr | output | 1 | Frame override applied |

## Verification
The bound checker watches the command word every cycle. It checks that bit 15 rises after an accepted update and falls one cycle later, that writes made while busy leave the word untouched, that a fetch echoes its index and select with bit 15 clear, that the word holds still when no write arrives, and that an output with its override flag clear equals the input priority. Whether the right fields land in the right record and table, whether a fetch returns them at the stated positions, which of the two queue pairs an AVB port uses, and whether a fetch-edit-update keeps the untouched pair can only be shown by the bench's update, fetch and lookup sequences compared against its own model of the table.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int CMD_W      = 16;
    localparam int TYPE_BITS  = 4;
    localparam int QPRI_W     = 2;
    localparam int FPRI_W     = 3;
    localparam int BIT_BUSY   = 15;
    localparam int BIT_SEL    = 12;
    localparam int PTR_LO     = 8;
    localparam int BIT_EN     = 3;
    localparam int BIT_AVB_EN = 7;
    localparam int AVB_LO     = 4;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } cmd_state_e;

    typedef struct packed {
        logic              q_en;
        logic [QPRI_W-1:0] q_pri;
        logic              a_en;
        logic [QPRI_W-1:0] a_pri;
        logic              f_en;
        logic [FPRI_W-1:0] f_pri;
    } ovr_entry_t;
endpackage

// File: rtl/pot_cmd_ctl.sv
module pot_cmd_ctl
    import pot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [CMD_W-1:0]     wdata_i,
    input  ovr_entry_t           fetch_ent_i,
    output logic [TYPE_BITS-1:0] fetch_ptr_o,
    output logic [CMD_W-1:0]     cmd_o,
    output logic                 upd_en_o,
    output logic                 upd_sel_o,
    output logic [TYPE_BITS-1:0] upd_ptr_o,
    output ovr_entry_t           upd_ent_o
);
    cmd_state_e       st_q, st_nxt;
    logic [CMD_W-1:0] cmd_q;
    logic [CMD_W-1:0] fetch_word;

    // Read port address for a fetch comes straight from the incoming word
    assign fetch_ptr_o = wdata_i[PTR_LO +: TYPE_BITS];

    // Word presented after a fetch: only the addressed table's fields are filled
    always_comb begin
        fetch_word = '0;
        fetch_word[PTR_LO +: TYPE_BITS] = wdata_i[PTR_LO +: TYPE_BITS];
        fetch_word[BIT_SEL] = wdata_i[BIT_SEL];
        if (wdata_i[BIT_SEL]) begin
            fetch_word[BIT_EN]        = fetch_ent_i.f_en;
            fetch_word[FPRI_W-1:0]    = fetch_ent_i.f_pri;
        end else begin
            fetch_word[BIT_EN]                = fetch_ent_i.q_en;
            fetch_word[QPRI_W-1:0]            = fetch_ent_i.q_pri;
            fetch_word[BIT_AVB_EN]            = fetch_ent_i.a_en;
            fetch_word[AVB_LO +: QPRI_W]      = fetch_ent_i.a_pri;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   if (wr_i && wdata_i[BIT_BUSY]) st_nxt = ST_COMMIT;
            ST_COMMIT: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Command word register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (wr_i) cmd_q <= wdata_i[BIT_BUSY] ? wdata_i : fetch_word;
                end
                ST_COMMIT: cmd_q[BIT_BUSY] <= 1'b0;
                default: cmd_q <= cmd_q;
            endcase
        end
    end

    assign cmd_o     = cmd_q;
    assign upd_en_o  = (st_q == ST_COMMIT);
    assign upd_sel_o = cmd_q[BIT_SEL];
    assign upd_ptr_o = cmd_q[PTR_LO +: TYPE_BITS];

    always_comb begin
        upd_ent_o       = '0;
        upd_ent_o.q_en  = cmd_q[BIT_EN];
        upd_ent_o.q_pri = cmd_q[QPRI_W-1:0];
        upd_ent_o.a_en  = cmd_q[BIT_AVB_EN];
        upd_ent_o.a_pri = cmd_q[AVB_LO +: QPRI_W];
        upd_ent_o.f_en  = cmd_q[BIT_EN];
        upd_ent_o.f_pri = cmd_q[FPRI_W-1:0];
    end
endmodule

// File: rtl/pot_store.sv
module pot_store
    import pot_pkg::*;
#(
    parameter int NUM_TYPES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en_i,
    input  logic                 upd_sel_i,
    input  logic [TYPE_BITS-1:0] upd_ptr_i,
    input  ovr_entry_t           upd_ent_i,
    input  logic [TYPE_BITS-1:0] fetch_ptr_i,
    output ovr_entry_t           fetch_ent_o,
    input  logic [TYPE_BITS-1:0] lk_ptr_i,
    output ovr_entry_t           lk_ent_o
);
    ovr_entry_t ent_q [NUM_TYPES];

    for (genvar gi = 0; gi < NUM_TYPES; gi++) begin : g_ent
        logic hit;
        assign hit = upd_en_i && (upd_ptr_i == TYPE_BITS'(gi));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[gi] <= '0;
            end else if (hit) begin
                if (upd_sel_i) begin
                    ent_q[gi].f_en  <= upd_ent_i.f_en;
                    ent_q[gi].f_pri <= upd_ent_i.f_pri;
                end else begin
                    ent_q[gi].q_en  <= upd_ent_i.q_en;
                    ent_q[gi].q_pri <= upd_ent_i.q_pri;
                    ent_q[gi].a_en  <= upd_ent_i.a_en;
                    ent_q[gi].a_pri <= upd_ent_i.a_pri;
                end
            end
        end
    end

    always_comb begin
        fetch_ent_o = '0;
        lk_ent_o    = '0;
        for (int k = 0; k < NUM_TYPES; k++) begin
            if (fetch_ptr_i == TYPE_BITS'(k)) fetch_ent_o = ent_q[k];
            if (lk_ptr_i == TYPE_BITS'(k))    lk_ent_o    = ent_q[k];
        end
    end
endmodule

// File: rtl/pot_lookup.sv
module pot_lookup
    import pot_pkg::*;
(
    input  ovr_entry_t        ent_i,
    input  logic              avb_i,
    input  logic [QPRI_W-1:0] qpri_i,
    input  logic [FPRI_W-1:0] fpri_i,
    output logic [QPRI_W-1:0] qpri_o,
    output logic              qovr_o,
    output logic [FPRI_W-1:0] fpri_o,
    output logic              fovr_o
);
    logic              sel_en;
    logic [QPRI_W-1:0] sel_pri;

    always_comb begin
        sel_en  = avb_i ? ent_i.a_en  : ent_i.q_en;
        sel_pri = avb_i ? ent_i.a_pri : ent_i.q_pri;
        qovr_o  = sel_en;
        qpri_o  = sel_en ? sel_pri : qpri_i;
        fovr_o  = ent_i.f_en;
        fpri_o  = ent_i.f_en ? ent_i.f_pri : fpri_i;
    end
endmodule

// File: rtl/prio_override_table.sv
module prio_override_table
    import pot_pkg::*;
#(
    parameter int NUM_TYPES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic [3:0]  lk_type,
    input  logic        lk_avb,
    input  logic [1:0]  in_qpri,
    input  logic [2:0]  in_fpri,
    output logic [1:0]  out_qpri,
    output logic        out_qovr,
    output logic [2:0]  out_fpri,
    output logic        out_fovr
);
    ovr_entry_t           fetch_ent, upd_ent, lk_ent;
    logic [TYPE_BITS-1:0] fetch_ptr, upd_ptr;
    logic                 upd_en, upd_sel;

    pot_cmd_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr),
        .wdata_i    (cfg_wdata),
        .fetch_ent_i(fetch_ent),
        .fetch_ptr_o(fetch_ptr),
        .cmd_o      (cfg_rdata),
        .upd_en_o   (upd_en),
        .upd_sel_o  (upd_sel),
        .upd_ptr_o  (upd_ptr),
        .upd_ent_o  (upd_ent)
    );

    pot_store #(.NUM_TYPES(NUM_TYPES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en_i   (upd_en),
        .upd_sel_i  (upd_sel),
        .upd_ptr_i  (upd_ptr),
        .upd_ent_i  (upd_ent),
        .fetch_ptr_i(fetch_ptr),
        .fetch_ent_o(fetch_ent),
        .lk_ptr_i   (lk_type),
        .lk_ent_o   (lk_ent)
    );

    pot_lookup u_lk (
        .ent_i (lk_ent),
        .avb_i (lk_avb),
        .qpri_i(in_qpri),
        .fpri_i(in_fpri),
        .qpri_o(out_qpri),
        .qovr_o(out_qovr),
        .fpri_o(out_fpri),
        .fovr_o(out_fovr)
    );
endmodule

// File: rtl/prio_override_chk.sv
module prio_override_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic [1:0]  in_qpri,
    input logic [2:0]  in_fpri,
    input logic [1:0]  out_qpri,
    input logic        out_qovr,
    input logic [2:0]  out_fpri,
    input logic        out_fovr
);
    assert_busy_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[15] && !cfg_rdata[15]) |=> cfg_rdata[15]);

    assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15] |=> !cfg_rdata[15]);

    assert_busy_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[15] && cfg_wr) |=> (cfg_rdata[14:0] == $past(cfg_rdata[14:0])));

    assert_fetch_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_wdata[15] && !cfg_rdata[15]) |=>
            (!cfg_rdata[15] && cfg_rdata[12:8] == $past(cfg_wdata[12:8])
             && cfg_rdata[14:13] == 2'b00));

    assert_word_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !cfg_rdata[15]) |=> $stable(cfg_rdata));

    assert_queue_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_qovr |-> (out_qpri == in_qpri));

    assert_frame_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fovr |-> (out_fpri == in_fpri));
endmodule

bind prio_override_table prio_override_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .in_qpri  (in_qpri),
    .in_fpri  (in_fpri),
    .out_qpri (out_qpri),
    .out_qovr (out_qovr),
    .out_fpri (out_fpri),
    .out_fovr (out_fovr)
);

// File: tb/tb_prio_override_table.sv
module tb_prio_override_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  lk_type = '0;
    logic        lk_avb = 1'b0;
    logic [1:0]  in_qpri = '0;
    logic [2:0]  in_fpri = '0;
    logic [1:0]  out_qpri;
    logic        out_qovr;
    logic [2:0]  out_fpri;
    logic        out_fovr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // bench model of the table
    bit       m_qen [16];
    bit [1:0] m_qp  [16];
    bit       m_aen [16];
    bit [1:0] m_ap  [16];
    bit       m_fen [16];
    bit [2:0] m_fp  [16];

    always #4 clk = ~clk;

    prio_override_table dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lk_type(lk_type), .lk_avb(lk_avb),
        .in_qpri(in_qpri), .in_fpri(in_fpri), .out_qpri(out_qpri),
        .out_qovr(out_qovr), .out_fpri(out_fpri), .out_fovr(out_fovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fetch_exp(input bit sel, input logic [3:0] p);
        logic [15:0] w = '0;
        w[11:8] = p;
        w[12] = sel;
        if (sel) begin
            w[3] = m_fen[p]; w[2:0] = m_fp[p];
        end else begin
            w[3] = m_qen[p]; w[1:0] = m_qp[p];
            w[7] = m_aen[p]; w[5:4] = m_ap[p];
        end
        return w;
    endfunction

    function automatic void model_update(input logic [15:0] d);
        logic [3:0] p = d[11:8];
        if (d[12]) begin
            m_fen[p] = d[3]; m_fp[p] = d[2:0];
        end else begin
            m_qen[p] = d[3]; m_qp[p] = d[1:0];
            m_aen[p] = d[7]; m_ap[p] = d[5:4];
        end
    endfunction

    // update write: R2/R3 via model, R4 busy timing
    task automatic sw_update(input logic [15:0] d);
        logic [15:0] w = d | 16'h8000;
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0;
        chk(cfg_rdata[15] == 1'b1, "R4 busy set", cfg_rdata, 1);
        @(negedge clk);
        chk(cfg_rdata == (w & 16'h7fff), "R4 busy cleared", cfg_rdata, w & 16'h7fff);
        model_update(w);
    endtask

    task automatic sw_fetch(input bit sel, input logic [3:0] p, input logic [7:0] junk);
        logic [15:0] e;
        @(negedge clk); cfg_wr = 1'b1;
        cfg_wdata = {1'b0, junk[1:0], sel, p, junk};
        @(negedge clk); cfg_wr = 1'b0;
        e = fetch_exp(sel, p);
        chk(cfg_rdata == e, "R6 fetch word", cfg_rdata, e);
    endtask

    task automatic lk_check(input logic [3:0] t, input bit avb, input logic [1:0] iq, input logic [2:0] ifp);
        logic [1:0] eq; bit eqo; logic [2:0] ef; bit efo;
        lk_type = t; lk_avb = avb; in_qpri = iq; in_fpri = ifp;
        #1;
        eqo = avb ? m_aen[t] : m_qen[t];
        eq  = eqo ? (avb ? m_ap[t] : m_qp[t]) : iq;
        efo = m_fen[t];
        ef  = efo ? m_fp[t] : ifp;
        if (avb) chk(out_qpri == eq && out_qovr == eqo, "R8 avb queue lookup", {out_qovr, out_qpri}, {eqo, eq});
        else     chk(out_qpri == eq && out_qovr == eqo, "R7 queue lookup", {out_qovr, out_qpri}, {eqo, eq});
        chk(out_fpri == ef && out_fovr == efo, "R9 frame lookup", {out_fovr, out_fpri}, {efo, ef});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            m_qen[i] = 0; m_qp[i] = 0; m_aen[i] = 0; m_ap[i] = 0; m_fen[i] = 0; m_fp[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cfg_rdata == 16'h0000, "R1 reset word", cfg_rdata, 0);
        for (int t = 0; t < 16; t++) begin
            lk_type = 4'(t); lk_avb = t[0]; in_qpri = 2'(t); in_fpri = 3'(t + 1);
            #1;
            chk(out_qpri == 2'(t) && !out_qovr && out_fpri == 3'(t + 1) && !out_fovr,
                "R1 reset pass-through", {out_fovr, out_fpri, out_qovr, out_qpri}, {1'b0, 3'(t + 1), 1'b0, 2'(t)});
        end

        // R2: queue update at the boundary indexes, frame fields untouched
        sw_update(16'h00B9);             // entry 0: q_en=1 q=1, avb en=1 pri=3
        sw_update(16'h0F8A);             // entry 15: q_en=1 q=2, avb_en=1 pri=0
        lk_check(4'd0, 1'b0, 2'd3, 3'd5);
        lk_check(4'd0, 1'b1, 2'd0, 3'd2);
        lk_check(4'd15, 1'b0, 2'd0, 3'd7);
        lk_check(4'd15, 1'b1, 2'd2, 3'd1);

        // R3: frame update, queue fields untouched
        sw_update(16'h1F0E);             // entry 15 frame: en=1 pri=6
        lk_check(4'd15, 1'b0, 2'd1, 3'd0);
        chk(out_qpri == 2'd2, "R3 queue kept", out_qpri, 2);

        // R5: write during busy is dropped
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 16'h850B;   // entry 5 queue en=1 q=3
        @(negedge clk); cfg_wdata = 16'h8509;                  // arrives in busy cycle
        @(negedge clk); cfg_wr = 1'b0;
        chk(cfg_rdata == 16'h050B, "R5 busy write dropped word", cfg_rdata, 16'h050B);
        model_update(16'h850B);
        lk_check(4'd5, 1'b0, 2'd0, 3'd0);
        chk(out_qpri == 2'd3, "R5 busy write dropped table", out_qpri, 3);

        // R6: fetches of both tables
        sw_fetch(1'b0, 4'd0, 8'h44);
        sw_fetch(1'b1, 4'd15, 8'hFF);
        sw_fetch(1'b1, 4'd3, 8'h00);
        lk_check(4'd0, 1'b1, 2'd0, 3'd0);

        // R10: fetch, edit AVB pair only, update; normal pair kept
        sw_update(16'h070A);             // entry 7: q_en=1 q=2, avb off
        sw_fetch(1'b0, 4'd7, 8'h00);
        w = cfg_rdata;
        w[7] = 1'b1; w[5:4] = 2'd1;
        sw_update(w);
        lk_check(4'd7, 1'b0, 2'd0, 3'd3);
        chk(out_qpri == 2'd2 && out_qovr, "R10 normal pair kept", out_qpri, 2);
        lk_check(4'd7, 1'b1, 2'd3, 3'd3);
        chk(out_qpri == 2'd1 && out_qovr, "R10 avb pair edited", out_qpri, 1);

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) begin
                w = 16'($urandom);
                sw_update(w);
            end else if (op < 5) begin
                sw_fetch(1'($urandom), 4'($urandom), 8'($urandom));
            end else begin
                @(negedge clk);
                lk_check(4'($urandom), 1'($urandom), 2'($urandom), 3'($urandom));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule